// File: doc/BRIEF.md
# Gated 13-Bit Counter/Timer

This block is a 13-bit up-counter that software programs through a small byte-wide register port. The count is held as a 5-bit low part and an 8-bit high part that behave as one counter: the low part carries into the high part. Three count sources are offered. The first is a falling edge on an external count pin. The second is every system clock. The third is a one-cycle tick from a prescaler that lives outside the block.

Counting is enabled by a software run bit. An optional gate can also qualify it: an external level input whose active level software chooses. This makes the block usable for pulse-width measurement. When the count rolls past its maximum it wraps to zero and sets a sticky overflow flag. The flag drives the interrupt request until software clears it or an acknowledge pulse arrives.

Top module: `gtmr_timer13`

## Requirements
- R1: After a synchronous active-low reset, the low part, the high part and the control register read as 0, and irq is low.
- R2: Address 0 holds the low 5 bits of the count in rd_data[4:0], with rd_data[7:5] always reading 0. Address 1 holds the upper 8 bits. The count value is high*32 + low, so a low part of 31 that advances becomes 0 and the high part goes up by one. Address 3 reads 0.
- R3: With control bit 2 (pin select) at 1, each falling edge on cnt_pin adds exactly one to the count, at most one per clock. The increment lands on the third rising clock edge after the pin is first sampled low.
- R4: With control bit 2 at 0 and bit 3 (system clock select) at 1, the count advances by one on every clock edge while enabled.
- R5: With control bits 2 and 3 both at 0, the count advances by one on each clock edge at which presc_tick is 1 while enabled.
- R6: Control bit 0 (run) at 0 stops counting. With run at 1 and bit 1 (gate enable) at 0, the counter runs. With run at 1 and gate enable at 1, it runs only while the gate input is active.
- R7: The gate input is active when gate_in XOR control bit 4 (polarity) equals 1. gate_in passes through a two-flop synchroniser before it is used.
- R8: Starting the counter does not clear it; counting continues from the loaded value.
- R9: An increment from 0x1FFF wraps the count to 0 and sets the overflow flag. The flag reads at address 2 bit 5 and drives irq high.
- R10: A write to the low or high part wins over an increment in the same cycle. The written part takes the data, the other part keeps its value, and no increment happens that cycle.
- R11: The flag is loaded from bit 5 of a control write and cleared by an int_ack pulse. An overflow in the same cycle as either of these leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 low part, 1 high part, 2 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Combinational read data |
| cnt_pin | input | 1 | External count input, asynchronous |
| gate_in | input | 1 | External gate level, asynchronous |
| presc_tick | input | 1 | One-cycle prescaled clock tick |
| int_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Interrupt request, equal to the overflow flag |

## Verification
Register writes take effect at the rising edge that samples the strobe. Their result is readable at the following falling edge, when the bench reads it. A system-clock or tick increment lands on the edge that samples the enable. A pin fall counts on the third edge after the pin goes low, and a gate change takes effect after two edges. The bench drives every input at a falling edge and counts exact edge windows between a run-on write and a run-off write. It leaves several settling cycles after pin or gate changes before it compares the count with the arithmetically expected total. The same-cycle cases (write against increment, acknowledge against overflow) are aligned by reading the count one edge before the collision.

// File: rtl/gtmr_pkg.sv
// Package: shared register map, control bit positions and types for the
// gated 13-bit counter/timer. Assumes a 2-bit register address.
package gtmr_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_CNT_LO = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_CNT_HI = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 2'd2;

    localparam int unsigned CB_RUN  = 0;
    localparam int unsigned CB_GATE = 1;
    localparam int unsigned CB_PIN  = 2;
    localparam int unsigned CB_SYS  = 3;
    localparam int unsigned CB_POL  = 4;
    localparam int unsigned CB_FLAG = 5;
    localparam int unsigned CTRL_W  = 5;

    typedef enum logic [1:0] {
        SRC_PRESC  = 2'd0,
        SRC_SYSCLK = 2'd1,
        SRC_PIN    = 2'd2
    } src_e;

    // Field order matches the CB_* bit positions (run is bit 0).
    typedef struct packed {
        logic pol;
        logic sys_sel;
        logic pin_sel;
        logic gate_en;
        logic run;
    } ctrl_t;

    // Resolve the two select bits into one source code; the pin select dominates.
    function automatic src_e pick_src(input ctrl_t c);
        if (c.pin_sel)      return SRC_PIN;
        else if (c.sys_sel) return SRC_SYSCLK;
        else                return SRC_PRESC;
    endfunction

endpackage

// File: rtl/gtmr_sync.sv
// Module: gtmr_sync
// Multi-flop synchroniser for one asynchronous level. Resets to 0.
// Assumes STAGES >= 1; latency is STAGES rising edges.
module gtmr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the sampled level along the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gtmr_pin_edge.sv
// Module: gtmr_pin_edge
// Synchronises the external count pin and flags a high-to-low transition
// for one cycle. Assumes the pin is slow relative to clk (at most one edge
// is reported per clock by construction of the previous/current compare).
module gtmr_pin_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);

    logic pin_s;
    logic prev_q;

    gtmr_sync #(.STAGES(STAGES)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin),
        .q     (pin_s)
    );

    // Hold the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    assign fall = prev_q & ~pin_s;

    AST_SINGLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R3

endmodule

// File: rtl/gtmr_run_ctl.sv
// Module: gtmr_run_ctl
// Combines the run bit, the optional polarity-adjusted gate and the chosen
// count source into a single increment request. Purely combinational.
// Assumes gate_s and pin_fall are already synchronous to clk.
module gtmr_run_ctl
    import gtmr_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  gate_s,
    input  logic  pin_fall,
    input  logic  presc_tick,
    output logic  inc
);

    logic gate_active;
    logic enabled;
    src_e src;

    // Decide whether the counter may run this cycle.
    always_comb begin
        gate_active = gate_s ^ ctrl.pol;
        enabled     = ctrl.run & (~ctrl.gate_en | gate_active);
        src         = pick_src(ctrl);
    end

    // Pick the per-cycle count event for the selected source.
    always_comb begin
        case (src)
            SRC_PIN:    inc = enabled & pin_fall;
            SRC_SYSCLK: inc = enabled;
            SRC_PRESC:  inc = enabled & presc_tick;
            default:    inc = 1'b0;
        endcase
    end

endmodule

// File: rtl/gtmr_count.sv
// Module: gtmr_count
// Split low/high counter with write-over-increment priority and the sticky
// overflow flag. Assumes HI_W >= LO_W so the write data covers both parts.
module gtmr_count #(
    parameter int unsigned LO_W = 5,
    parameter int unsigned HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [HI_W-1:0] wdata,
    input  logic            flag_wr,
    input  logic            flag_wdata,
    input  logic            ack,
    output logic [LO_W-1:0] lo,
    output logic [HI_W-1:0] hi,
    output logic            flag
);

    localparam int unsigned CNT_W = LO_W + HI_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             wr_any;
    logic             step;
    logic             ovf;

    // Resolve priority: any part write suppresses the increment.
    always_comb begin
        wr_any = wr_lo | wr_hi;
        step   = inc & ~wr_any;
        ovf    = step & (cnt_q == CNT_MAX);
    end

    // Update the count from a write or from one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_any) begin
            if (wr_lo) cnt_q[LO_W-1:0]     <= wdata[LO_W-1:0];
            if (wr_hi) cnt_q[CNT_W-1:LO_W] <= wdata;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Keep the overflow flag; a new overflow beats any clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (ovf)     flag_q <= 1'b1;
        else if (ack)     flag_q <= 1'b0;
        else if (flag_wr) flag_q <= flag_wdata;
    end

    assign lo   = cnt_q[LO_W-1:0];
    assign hi   = cnt_q[CNT_W-1:LO_W];
    assign flag = flag_q;

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_lo && !wr_hi && cnt_q == CNT_MAX) |=> (cnt_q == '0 && flag_q)); // R9
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_lo && !wr_hi && cnt_q != CNT_MAX) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_lo && !wr_hi) |=> $stable(cnt_q)); // R6
    AST_LO_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> lo == $past(wdata[LO_W-1:0])); // R10
    AST_HI_KEEPS_ON_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> $stable(hi)); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !ack && !flag_wr) |=> flag_q); // R11

endmodule

// File: rtl/gtmr_timer13.sv
// Module: gtmr_timer13 (top)
// 13-bit gated counter/timer with register port, three count sources,
// polarity-selectable gate and sticky overflow interrupt.
// Assumes DATA_W >= HI_W >= LO_W and DATA_W >= 6 for the control byte.
module gtmr_timer13
    import gtmr_pkg::*;
#(
    parameter int unsigned LO_W        = 5,
    parameter int unsigned HI_W        = 8,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  cnt_pin,
    input  logic                  gate_in,
    input  logic                  presc_tick,
    input  logic                  int_ack,
    output logic                  irq
);

    localparam int unsigned LO_PAD   = DATA_W - LO_W;
    localparam int unsigned HI_PAD   = DATA_W - HI_W;
    localparam int unsigned CTRL_PAD = DATA_W - CTRL_W - 1;

    ctrl_t           ctrl_q;
    logic            wr_lo;
    logic            wr_hi;
    logic            wr_ctrl;
    logic            gate_s;
    logic            pin_fall;
    logic            inc;
    logic [LO_W-1:0] cnt_lo;
    logic [HI_W-1:0] cnt_hi;
    logic            flag;

    // Decode the write strobe into per-register enables.
    always_comb begin
        wr_lo   = wr_en & (wr_addr == ADDR_CNT_LO);
        wr_hi   = wr_en & (wr_addr == ADDR_CNT_HI);
        wr_ctrl = wr_en & (wr_addr == ADDR_CTRL);
    end

    // Hold the control bits written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    gtmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gate_in),
        .q     (gate_s)
    );

    gtmr_pin_edge #(.STAGES(SYNC_STAGES)) u_pin_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cnt_pin),
        .fall  (pin_fall)
    );

    gtmr_run_ctl u_run_ctl (
        .ctrl       (ctrl_q),
        .gate_s     (gate_s),
        .pin_fall   (pin_fall),
        .presc_tick (presc_tick),
        .inc        (inc)
    );

    gtmr_count #(.LO_W(LO_W), .HI_W(HI_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (inc),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wdata      (wr_data[HI_W-1:0]),
        .flag_wr    (wr_ctrl),
        .flag_wdata (wr_data[CB_FLAG]),
        .ack        (int_ack),
        .lo         (cnt_lo),
        .hi         (cnt_hi),
        .flag       (flag)
    );

    // Return the addressed register, zero-extended.
    always_comb begin
        case (rd_addr)
            ADDR_CNT_LO: rd_data = {{LO_PAD{1'b0}}, cnt_lo};
            ADDR_CNT_HI: rd_data = {{HI_PAD{1'b0}}, cnt_hi};
            ADDR_CTRL:   rd_data = {{CTRL_PAD{1'b0}}, flag, ctrl_q};
            default:     rd_data = '0;
        endcase
    end

    assign irq = flag;

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !wr_lo && !wr_hi) |=> $stable({cnt_hi, cnt_lo})); // R6
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.gate_en && !(gate_s ^ ctrl_q.pol) && !wr_lo && !wr_hi) |=> $stable({cnt_hi, cnt_lo})); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !inc) |=> !irq); // R11

endmodule

// File: tb/gtmr_timer13_test.sv
// Self-checking bench for gtmr_timer13. Inputs change at falling edges;
// outputs are read at falling edges.
module gtmr_timer13_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cnt_pin = 1'b1;
    logic       gate_in = 1'b0;
    logic       presc_tick = 1'b0;
    logic       int_ack = 1'b0;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gtmr_timer13 uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_pin(cnt_pin), .gate_in(gate_in), .presc_tick(presc_tick),
        .int_ack(int_ack), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Caller stands at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a; #1; v = int'(rd_data);
    endtask

    task automatic get_cnt(output int v);
        int lo, hi;
        rd(2'd0, lo); rd(2'd1, hi);
        v = hi * 32 + lo;
    endtask

    task automatic load(input int v);
        wr(2'd0, 8'(v % 32));
        wr(2'd1, 8'(v / 32));
    endtask

    // Exactly n edges with the given control value active.
    task automatic run_window(input logic [7:0] c, input int n);
        wr(2'd2, c);
        repeat (n - 1) @(negedge clk);
        wr(2'd2, c & 8'hFE);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, v2, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1", "low after reset", v, 0);
        rd(2'd1, v); chk("R1", "high after reset", v, 0);
        rd(2'd2, v); chk("R1", "ctrl after reset", v, 0);
        chk("R1", "irq after reset", int'(irq), 0);
        rd(2'd3, v); chk("R2", "unused address", v, 0);

        // R2 field widths
        wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2", "low masks upper bits", v, 8'h1F);
        wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2", "high full byte", v, 8'hA5);

        // R2/R8 carry from low into high, starting from loaded value
        load(16'h5F);
        wr(2'd2, 8'h09);
        wr(2'd2, 8'h00);
        rd(2'd0, v); chk("R2", "low after carry", v, 0);
        rd(2'd1, v); chk("R2", "high after carry", v, 3);
        load(16'h123);
        run_window(8'h09, 5);
        get_cnt(v); chk("R8", "count continues from load", v, 16'h128);

        // R6/R7 run/gate/polarity truth table with system clock source
        for (int r = 0; r < 2; r++)
            for (int g = 0; g < 2; g++)
                for (int p = 0; p < 2; p++)
                    for (int gi = 0; gi < 2; gi++) begin
                        gate_in = gi[0];
                        load(0);
                        run_window({3'b0, p[0], 1'b1, 1'b0, g[0], r[0]}, 10);
                        exp = (r == 1 && (g == 0 || (gi ^ p) == 1)) ? 10 : 0;
                        get_cnt(v);
                        chk((g == 1) ? "R7" : "R6", $sformatf("run=%0d gate=%0d pol=%0d in=%0d", r, g, p, gi), v, exp);
                    end
        gate_in = 1'b0;

        // R5 prescaled tick source
        load(0);
        exp = 0;
        wr(2'd2, 8'h01);
        for (int i = 0; i < 20; i++) begin
            presc_tick = (i % 3 == 0);
            if (presc_tick) exp++;
            @(negedge clk);
        end
        presc_tick = 1'b0;
        wr(2'd2, 8'h00);
        get_cnt(v); chk("R5", "tick count", v, exp);

        // R3 pin falling edges, varied widths, then fastest toggle
        load(0);
        wr(2'd2, 8'h05);
        for (int k = 0; k < 6; k++) begin
            cnt_pin = 1'b0; repeat (1 + k % 3) @(negedge clk);
            cnt_pin = 1'b1; repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        get_cnt(v); chk("R3", "six pin pulses", v, 6);
        for (int k = 0; k < 5; k++) begin
            cnt_pin = 1'b0; @(negedge clk);
            cnt_pin = 1'b1; @(negedge clk);
        end
        repeat (4) @(negedge clk);
        get_cnt(v); chk("R3", "fast toggle pulses", v, 11);
        wr(2'd2, 8'h00);

        // R9 overflow via system clock
        load(16'h1FFD);
        wr(2'd2, 8'h09);
        repeat (3) @(negedge clk);
        get_cnt(v); chk("R9", "sysclk wrap count", v, 0);
        chk("R9", "sysclk irq", int'(irq), 1);
        rd(2'd2, v); chk("R9", "flag bit 5", (v >> 5) & 1, 1);
        wr(2'd2, 8'h20);
        wr(2'd2, 8'h00);
        chk("R11", "software clear", int'(irq), 0);

        // R9 overflow via prescaled tick, then R11 acknowledge
        load(16'h1FFF);
        wr(2'd2, 8'h01);
        presc_tick = 1'b1; @(negedge clk); presc_tick = 1'b0;
        get_cnt(v); chk("R9", "tick wrap count", v, 0);
        chk("R9", "tick irq", int'(irq), 1);
        int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
        chk("R11", "ack clears", int'(irq), 0);
        wr(2'd2, 8'h00);

        // R9 overflow via pin
        load(16'h1FFF);
        wr(2'd2, 8'h05);
        cnt_pin = 1'b0; repeat (2) @(negedge clk);
        cnt_pin = 1'b1; repeat (4) @(negedge clk);
        get_cnt(v); chk("R9", "pin wrap count", v, 0);
        chk("R9", "pin irq", int'(irq), 1);
        wr(2'd2, 8'h20);

        // R11 acknowledge in the same cycle as overflow
        load(16'h1FFC);
        wr(2'd2, 8'h29);
        repeat (3) @(negedge clk);
        get_cnt(v); chk("R11", "count before collision", v, 16'h1FFF);
        int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
        chk("R11", "overflow beats ack", int'(irq), 1);
        get_cnt(v); chk("R9", "wrap at collision", v, 0);

        // R10 writes beat the running increment
        wr(2'd0, 8'h03);
        rd(2'd0, v); chk("R10", "low write wins", v, 3);
        @(negedge clk);
        rd(2'd0, v); chk("R10", "counting resumes", v, 4);
        rd(2'd0, v2);
        wr(2'd1, 8'h40);
        rd(2'd1, v); chk("R10", "high write wins", v, 8'h40);
        rd(2'd0, v); chk("R10", "low held on high write", v, v2);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R11", "control write clears flag", v, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule